// File: doc/BRIEF.md
# Type-0 PCI Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one PCI device function. A configuration agent reaches it through a one-cycle access port that carries a byte offset, a byte count, a write flag and 32 bits of write data; one cycle later the block returns a response with read data and an error flag. Identification fields, the interrupt pin, the grant and latency limits, and the type bits of every base address register come from parameters and read back as constants after reset.

Six base address registers support the usual sizing handshake: software writes all ones, reads back a mask that encodes the region size, then writes the real base. A register whose size parameter is zero is absent and reads as zero. Each present register drives a decode window (valid flag, base, size) that a bus decoder uses to claim cycles. The expansion ROM register has its own sizing value. A few control bytes and the 16-bit command register can be written, and every other write is dropped quietly.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset, dword 0x00 reads {device id, vendor id}, 0x08 reads {class code, revision}, 0x2C reads {subsystem id, subsystem vendor id}, 0x3C reads {max latency, min grant, interrupt pin, 0x00}. Command, status, cache line size, latency timer, interrupt line and the ROM register read zero. A memory BAR reads only its type bits (bit 3 = prefetchable) and an I/O BAR reads 0x1.
- R2: Every access taken with acc_valid gives rsp_valid in the next cycle. A legal read returns the bytes at offset, offset+1, and so on up to the byte count, packed little-endian from bit 0, and zero in the byte lanes above the count. Writes return zero data.
- R3: An access whose byte count acc_size is not 1, 2 or 4, or whose offset plus count exceeds 64, returns rsp_err = 1 and zero data, and changes no register.
- R4: A 1-byte write at 0x0C (cache line size), 0x0D (latency timer) or 0x3C (interrupt line) changes that byte only.
- R5: A 2- or 4-byte write at 0x04 loads wdata[15:0] into the command register. Status at 0x06 stays zero.
- R6: A 4-byte write of 0xFFFFFFFF at 0x10 + 4n to a present BAR n of size 2^k makes it read ~(2^k - 1) with the read-only type bits unchanged.
- R7: Any other 4-byte write to a present BAR stores wdata in its writable bits and keeps its type bits, which are bits 1:0 (value 01) for an I/O BAR and bits 3:0 for a memory BAR.
- R8: After an ordinary BAR write with nonzero address bits, win_vld[n] = 1, win_base[n] = the address bits and win_size[n] = 2^k. A write with zero address bits clears win_vld[n]. A sizing write leaves the window as it was. Windows change in the cycle the response appears.
- R9: A BAR whose size parameter is zero always reads zero, ignores writes and never raises win_vld.
- R10: A 4-byte write of 0xFFFFFFFE at 0x30 makes the ROM register read 0xFFFFFFFF. Any other 4-byte write there is stored unchanged.
- R11: Legal writes to any other location are ignored without error. This covers identification fields, interrupt pin, min grant, max latency, status, and partial BAR or ROM writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_off | input | 8 | Byte offset into configuration space |
| acc_size | input | 3 | Byte count of the access |
| acc_wdata | input | 32 | Write data, little-endian from bit 0 |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Access was rejected |
| rsp_data | output | 32 | Read data |
| win_vld | output | 6 | Per-BAR decode window enabled |
| win_base | output | 192 | Per-BAR window base, 32 bits each, BAR n at [32n +: 32] |
| win_size | output | 192 | Per-BAR window size in bytes, 32 bits each |

## Verification
A single write to a BAR updates two things in the same edge: the value a later read returns, and the decode window. The two must agree for an ordinary write. For a sizing write they must part, with the register reading back the mask while the window keeps its old base. The bench places a window, sizes the same BAR, then reads the BAR back and samples win_vld and win_base right after the sizing write. It also moves the window with a new base and then clears it with a zero base. In each case it judges the readback against the sizing rule and the window outputs against the previous ordinary write.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int NUM_BAR   = 6;
  localparam int DW        = 32;
  localparam int HDR_BYTES = 64;
  localparam int HDR_WORDS = HDR_BYTES / 4;

  localparam logic [7:0] OFF_CMD   = 8'h04;
  localparam logic [7:0] OFF_CLS   = 8'h0C;
  localparam logic [7:0] OFF_LAT   = 8'h0D;
  localparam logic [7:0] OFF_BAR0  = 8'h10;
  localparam logic [7:0] OFF_BARN  = 8'h24;
  localparam logic [7:0] OFF_ROM   = 8'h30;
  localparam logic [7:0] OFF_ILINE = 8'h3C;

  localparam logic [31:0] SIZE_PROBE = 32'hFFFF_FFFF;
  localparam logic [31:0] ROM_PROBE  = 32'hFFFF_FFFE;

  typedef enum logic [2:0] {
    WT_NONE, WT_CMD, WT_CLS, WT_LAT, WT_ILINE, WT_BAR, WT_ROM
  } wr_tgt_e;
endpackage

// File: rtl/cfg_acc_decode.sv
module cfg_acc_decode
  import cfg_hdr_pkg::*;
(
  input  logic       acc_valid,
  input  logic       acc_we,
  input  logic [7:0] acc_off,
  input  logic [2:0] acc_size,
  output logic       bad_acc,
  output wr_tgt_e    wr_tgt,
  output logic [2:0] bar_sel
);
  logic       size_ok;
  logic [8:0] end_pos;

  always_comb begin
    size_ok = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
    end_pos = {1'b0, acc_off} + {6'd0, acc_size};
    bad_acc = acc_valid && (!size_ok || (end_pos > 9'(HDR_BYTES)));
    bar_sel = 3'(acc_off[5:2] - 4'd4);
    wr_tgt  = WT_NONE;
    if (acc_valid && acc_we && !bad_acc) begin
      if (acc_size == 3'd1) begin
        if (acc_off == OFF_CLS)        wr_tgt = WT_CLS;
        else if (acc_off == OFF_LAT)   wr_tgt = WT_LAT;
        else if (acc_off == OFF_ILINE) wr_tgt = WT_ILINE;
      end else if (acc_off == OFF_CMD) begin
        wr_tgt = WT_CMD;
      end else if (acc_size == 3'd4) begin
        if (acc_off >= OFF_BAR0 && acc_off <= OFF_BARN && acc_off[1:0] == 2'b00)
          wr_tgt = WT_BAR;
        else if (acc_off == OFF_ROM)
          wr_tgt = WT_ROM;
      end
    end
  end
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfg_hdr_pkg::*;
#(
  parameter int         SIZE_LOG2 = 12,
  parameter logic       IS_IO     = 1'b0,
  parameter logic       PREFETCH  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] bar_val,
  output logic          win_vld,
  output logic [DW-1:0] win_base,
  output logic [DW-1:0] win_size
);
  generate
    if (SIZE_LOG2 == 0) begin : g_absent
      logic unused_slot;
      assign unused_slot = ^{clk, rst_n, wr_en, wdata};
      assign bar_val  = '0;
      assign win_vld  = 1'b0;
      assign win_base = '0;
      assign win_size = '0;
    end else begin : g_present
      localparam int          RO_W     = IS_IO ? 2 : 4;
      localparam logic [31:0] RO_MASK  = (32'd1 << RO_W) - 32'd1;
      localparam logic [31:0] RO_VAL   = IS_IO ? 32'h1 : {28'd0, PREFETCH, 3'b000};
      localparam logic [31:0] SZ_BYTES = 32'd1 << SIZE_LOG2;
      localparam logic [31:0] SZ_MASK  = ~(SZ_BYTES - 32'd1);

      logic          probe;
      logic [DW-1:0] addr_q, addr_d, base_q, base_d;
      logic          vld_q, vld_d;

      always_comb begin
        probe  = (wdata == SIZE_PROBE);
        addr_d = addr_q;
        base_d = base_q;
        vld_d  = vld_q;
        if (wr_en) begin
          if (probe) begin
            addr_d = SZ_MASK & ~RO_MASK;
          end else begin
            addr_d = wdata & ~RO_MASK;
            base_d = wdata & ~RO_MASK;
            vld_d  = |(wdata & ~RO_MASK);
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          addr_q <= '0;
          base_q <= '0;
          vld_q  <= 1'b0;
        end else if (wr_en) begin
          addr_q <= addr_d;
          base_q <= base_d;
          vld_q  <= vld_d;
        end
      end

      assign bar_val  = addr_q | RO_VAL;
      assign win_vld  = vld_q;
      assign win_base = base_q;
      assign win_size = SZ_BYTES;

      // R6
      size_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wdata == SIZE_PROBE) |=> bar_val == (SZ_MASK | RO_VAL));
      // R8
      win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wdata == SIZE_PROBE) |=> $stable(win_base) && $stable(win_vld));
      // R7
      type_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wdata != SIZE_PROBE) |=>
          bar_val == (($past(wdata) & ~RO_MASK) | RO_VAL));
    end
  endgenerate
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID   = 16'h0F17,
  parameter logic [7:0]  REVISION    = 8'h02,
  parameter logic [23:0] CLASS_CODE  = 24'h020000,
  parameter logic [7:0]  HDR_TYPE    = 8'h00,
  parameter logic [15:0] SUBSYS_VID  = 16'hA5C3,
  parameter logic [15:0] SUBSYS_ID   = 16'h0001,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [7:0]  MIN_GRANT   = 8'h04,
  parameter logic [7:0]  MAX_LAT     = 8'h10,
  parameter logic [5:0]  BAR_IS_IO   = 6'b000010,
  parameter logic [5:0]  BAR_PREF    = 6'b000100,
  parameter logic [35:0] BAR_SZ_LOG2 = {6'd0, 6'd0, 6'd0, 6'd20, 6'd8, 6'd12}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_we,
  input  logic [7:0]            acc_off,
  input  logic [2:0]            acc_size,
  input  logic [31:0]           acc_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [31:0]           rsp_data,
  output logic [NUM_BAR-1:0]    win_vld,
  output logic [NUM_BAR*DW-1:0] win_base,
  output logic [NUM_BAR*DW-1:0] win_size
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic    bad_acc;
  wr_tgt_e wr_tgt;
  logic [2:0] bar_sel;

  cfg_acc_decode u_dec (
    .acc_valid (acc_valid),
    .acc_we    (acc_we),
    .acc_off   (acc_off),
    .acc_size  (acc_size),
    .bad_acc   (bad_acc),
    .wr_tgt    (wr_tgt),
    .bar_sel   (bar_sel)
  );

  logic [DW-1:0] bar_val [NUM_BAR];

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
    cfg_bar_slot #(
      .SIZE_LOG2 (int'(BAR_SZ_LOG2[i*6 +: 6])),
      .IS_IO     (BAR_IS_IO[i]),
      .PREFETCH  (BAR_PREF[i])
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .wr_en    ((wr_tgt == WT_BAR) && (bar_sel == 3'(i))),
      .wdata    (acc_wdata),
      .bar_val  (bar_val[i]),
      .win_vld  (win_vld[i]),
      .win_base (win_base[i*DW +: DW]),
      .win_size (win_size[i*DW +: DW])
    );
  end

  logic [15:0] cmd_q, cmd_d;
  logic [7:0]  cls_q, cls_d, lat_q, lat_d, iline_q, iline_d;
  logic [31:0] rom_q, rom_d;

  always_comb begin
    cmd_d   = cmd_q;
    cls_d   = cls_q;
    lat_d   = lat_q;
    iline_d = iline_q;
    rom_d   = rom_q;
    unique case (wr_tgt)
      WT_CMD:   cmd_d   = acc_wdata[15:0];
      WT_CLS:   cls_d   = acc_wdata[7:0];
      WT_LAT:   lat_d   = acc_wdata[7:0];
      WT_ILINE: iline_d = acc_wdata[7:0];
      WT_ROM:   rom_d   = (acc_wdata == ROM_PROBE) ? 32'hFFFF_FFFF : acc_wdata;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmd_q   <= '0;
      cls_q   <= '0;
      lat_q   <= '0;
      iline_q <= '0;
      rom_q   <= '0;
    end else if (wr_tgt != WT_NONE) begin
      cmd_q   <= cmd_d;
      cls_q   <= cls_d;
      lat_q   <= lat_d;
      iline_q <= iline_d;
      rom_q   <= rom_d;
    end
  end

  logic [31:0]              hdr_w [HDR_WORDS];
  logic [HDR_BYTES*8-1:0]   img;
  logic [31:0]              rdata;

  always_comb begin
    for (int w = 0; w < HDR_WORDS; w++) hdr_w[w] = '0;
    hdr_w[0]  = {DEVICE_ID, VENDOR_ID};
    hdr_w[1]  = {16'h0000, cmd_q};
    hdr_w[2]  = {CLASS_CODE, REVISION};
    hdr_w[3]  = {8'h00, HDR_TYPE, lat_q, cls_q};
    for (int b = 0; b < NUM_BAR; b++) hdr_w[4 + b] = bar_val[b];
    hdr_w[11] = {SUBSYS_ID, SUBSYS_VID};
    hdr_w[12] = rom_q;
    hdr_w[15] = {MAX_LAT, MIN_GRANT, INT_PIN, iline_q};
    for (int w = 0; w < HDR_WORDS; w++) img[w*32 +: 32] = hdr_w[w];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < 4; k++) begin
      logic [5:0] idx;
      idx = 6'(acc_off[5:0] + 6'(k));
      if (k < int'(acc_size)) rdata[8*k +: 8] = img[{idx, 3'b000} +: 8];
    end
  end

  logic        rsp_valid_d, rsp_err_d;
  logic [31:0] rsp_data_d;

  always_comb begin
    rsp_valid_d = acc_valid;
    rsp_err_d   = bad_acc;
    rsp_data_d  = (acc_valid && !acc_we && !bad_acc) ? rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rsp_data  <= rsp_data_d;
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    acc_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !acc_valid |=> !rsp_valid);
  // R3
  bad_acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    acc_valid && bad_acc |=> rsp_err && (rsp_data == 32'd0) && $stable(cmd_q) &&
      $stable(cls_q) && $stable(lat_q) && $stable(iline_q) && $stable(rom_q));
  // R10
  rom_probe_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_tgt == WT_ROM) && (acc_wdata == ROM_PROBE) |=> rom_q == 32'hFFFF_FFFF);
  // R5
  cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_tgt == WT_CMD) |=> cmd_q == $past(acc_wdata[15:0]));
endmodule

// File: tb/cfg_hdr_regs_bench.sv
`timescale 1ns/1ps
module cfg_hdr_regs_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         acc_valid, acc_we;
  logic [7:0]   acc_off;
  logic [2:0]   acc_size;
  logic [31:0]  acc_wdata;
  logic         rsp_valid, rsp_err;
  logic [31:0]  rsp_data;
  logic [5:0]   win_vld;
  logic [191:0] win_base, win_size;

  always #2.5 clk = ~clk;

  cfg_hdr_regs u_cfg_hdr_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_off(acc_off), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .win_vld(win_vld), .win_base(win_base), .win_size(win_size)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;

  exp_t exp_q [$];
  int   checks = 0;
  int   errors = 0;
  logic done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
        chk({e.tag, " data"}, rsp_data, e.data);
      end
    end
  end

  task automatic acc(input logic we, input logic [7:0] off, input logic [2:0] sz,
                     input logic [31:0] wd, input logic [31:0] exp_d,
                     input logic exp_e, input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b1; acc_we = we; acc_off = off; acc_size = sz; acc_wdata = wd;
    e.data = exp_d; e.err = exp_e; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, input logic [2:0] sz,
                    input logic [31:0] exp_d, input string tag);
    acc(1'b0, off, sz, 32'd0, exp_d, 1'b0, tag);
  endtask

  task automatic wr(input logic [7:0] off, input logic [2:0] sz,
                    input logic [31:0] wd, input string tag);
    acc(1'b1, off, sz, wd, 32'd0, 1'b0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_we = 1'b0;
    acc_off = '0; acc_size = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset image
    chk("R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    chk("R1 win_vld", {26'd0, win_vld}, 32'd0);
    rd(8'h00, 3'd4, 32'h0F17A5C3, "R1 ids");
    rd(8'h04, 3'd4, 32'h00000000, "R1 cmd/status");
    rd(8'h08, 3'd4, 32'h02000002, "R1 class/rev");
    rd(8'h0C, 3'd4, 32'h00000000, "R1 cls/lat");
    rd(8'h10, 3'd4, 32'h00000000, "R1 bar0 mem");
    rd(8'h14, 3'd4, 32'h00000001, "R1 bar1 io");
    rd(8'h18, 3'd4, 32'h00000008, "R1 bar2 pref");
    rd(8'h2C, 3'd4, 32'h0001A5C3, "R1 subsys");
    rd(8'h30, 3'd4, 32'h00000000, "R1 rom");
    rd(8'h3C, 3'd4, 32'h10040100, "R1 tail");

    // R2 sized and unaligned reads
    rd(8'h02, 3'd2, 32'h00000F17, "R2 half");
    rd(8'h3D, 3'd1, 32'h00000001, "R2 byte");
    rd(8'h3E, 3'd2, 32'h00001004, "R2 upper half");

    // R4 control bytes
    wr(8'h0C, 3'd1, 32'hFFFFFF40, "R4 cls wr");
    wr(8'h0D, 3'd1, 32'h00000020, "R4 lat wr");
    wr(8'h3C, 3'd1, 32'h0000000B, "R4 iline wr");
    rd(8'h0A, 3'd4, 32'h20400200, "R4 R2 unaligned cls/lat");
    rd(8'h3C, 3'd4, 32'h1004010B, "R4 iline");

    // R3 rejected accesses
    acc(1'b0, 8'h40, 3'd1, 32'd0, 32'd0, 1'b1, "R3 read past end");
    acc(1'b0, 8'h00, 3'd3, 32'd0, 32'd0, 1'b1, "R3 size 3");
    acc(1'b0, 8'h3E, 3'd4, 32'd0, 32'd0, 1'b1, "R3 crossing end");
    acc(1'b1, 8'h0C, 3'd3, 32'h55, 32'd0, 1'b1, "R3 bad size write");
    acc(1'b1, 8'h3C, 3'd0, 32'h55, 32'd0, 1'b1, "R3 size 0 write");
    rd(8'h0C, 3'd1, 32'h00000040, "R3 cls unchanged");
    rd(8'h3C, 3'd1, 32'h0000000B, "R3 iline unchanged");

    // R11 ignored writes
    wr(8'h3D, 3'd1, 32'hFF, "R11 pin wr");
    wr(8'h3F, 3'd1, 32'h77, "R11 maxlat wr");
    wr(8'h3C, 3'd4, 32'hFFFFFFFF, "R11 dword at iline");
    wr(8'h00, 3'd4, 32'h0, "R11 id wr");
    wr(8'h08, 3'd1, 32'h99, "R11 rev wr");
    rd(8'h3C, 3'd4, 32'h1004010B, "R11 tail unchanged");
    rd(8'h00, 3'd4, 32'h0F17A5C3, "R11 ids unchanged");
    rd(8'h08, 3'd4, 32'h02000002, "R11 class unchanged");

    // R5 command
    wr(8'h04, 3'd2, 32'h00000147, "R5 cmd half");
    rd(8'h04, 3'd4, 32'h00000147, "R5 cmd");
    wr(8'h04, 3'd4, 32'hFFFF0006, "R5 cmd dword");
    rd(8'h04, 3'd4, 32'h00000006, "R5 status stays zero");
    wr(8'h06, 3'd2, 32'h0000FFFF, "R11 status wr");
    rd(8'h04, 3'd4, 32'h00000006, "R11 status ignored");

    // R6 sizing
    wr(8'h10, 3'd4, 32'hFFFFFFFF, "R6 bar0 probe");
    chk("R8 probe no window", {31'd0, win_vld[0]}, 32'd0);
    rd(8'h10, 3'd4, 32'hFFFFF000, "R6 bar0 mask");
    wr(8'h14, 3'd4, 32'hFFFFFFFF, "R6 bar1 probe");
    rd(8'h14, 3'd4, 32'hFFFFFF01, "R6 bar1 io mask");
    wr(8'h18, 3'd4, 32'hFFFFFFFF, "R6 bar2 probe");
    rd(8'h18, 3'd4, 32'hFFF00008, "R6 bar2 pref mask");

    // R7 / R8 ordinary writes and windows
    wr(8'h10, 3'd4, 32'h80001007, "R7 bar0 wr");
    chk("R8 bar0 vld", {31'd0, win_vld[0]}, 32'd1);
    chk("R8 bar0 base", win_base[31:0], 32'h80001000);
    chk("R8 bar0 size", win_size[31:0], 32'h00001000);
    rd(8'h10, 3'd4, 32'h80001000, "R7 bar0 read");
    wr(8'h14, 3'd4, 32'h0000E102, "R7 bar1 wr");
    rd(8'h14, 3'd4, 32'h0000E101, "R7 bar1 io type kept");
    chk("R8 bar1 base", win_base[63:32], 32'h0000E100);
    chk("R8 bar1 size", win_size[63:32], 32'h00000100);

    // R8 sizing with live window: register and window diverge
    wr(8'h10, 3'd4, 32'hFFFFFFFF, "R8 bar0 reprobe");
    chk("R8 window kept vld", {31'd0, win_vld[0]}, 32'd1);
    chk("R8 window kept base", win_base[31:0], 32'h80001000);
    rd(8'h10, 3'd4, 32'hFFFFF000, "R6 bar0 mask again");
    wr(8'h10, 3'd4, 32'hC0000000, "R8 bar0 move");
    chk("R8 moved base", win_base[31:0], 32'hC0000000);
    wr(8'h12, 3'd2, 32'h0000AAAA, "R11 partial bar");
    rd(8'h10, 3'd4, 32'hC0000000, "R11 bar0 unchanged");
    wr(8'h10, 3'd4, 32'h0000000F, "R8 bar0 zero addr");
    chk("R8 window cleared", {31'd0, win_vld[0]}, 32'd0);
    rd(8'h10, 3'd4, 32'h00000000, "R7 bar0 type only");

    // R9 absent BAR
    wr(8'h1C, 3'd4, 32'h12345678, "R9 bar3 wr");
    rd(8'h1C, 3'd4, 32'h00000000, "R9 bar3 read");
    wr(8'h24, 3'd4, 32'hFFFFFFFF, "R9 bar5 probe");
    rd(8'h24, 3'd4, 32'h00000000, "R9 bar5 read");
    chk("R9 no windows", {26'd0, win_vld & 6'b111000}, 32'd0);

    // R10 ROM
    wr(8'h30, 3'd4, 32'hFFFFFFFE, "R10 rom probe");
    rd(8'h30, 3'd4, 32'hFFFFFFFF, "R10 rom probe read");
    wr(8'h30, 3'd4, 32'h000C0001, "R10 rom wr");
    rd(8'h30, 3'd4, 32'h000C0001, "R10 rom read");
    wr(8'h30, 3'd1, 32'h000000FF, "R11 rom byte");
    rd(8'h30, 3'd4, 32'h000C0001, "R11 rom unchanged");

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule